// File: doc/BRIEF.md
# Predicated Vector Halfword Store Sequencer

This block accepts one decoded-on-the-fly store instruction at a time and expands it into a stream of 16-bit memory write requests, one per active vector element. Alongside the 32-bit instruction word and a start strobe, the surrounding pipeline supplies the block with:

- the vector register value (VL bits),
- the predicate register value (VL/8 bits),
- a 64-bit general-register base,
- the 64-bit stack pointer.

The block checks the instruction pattern and works out the element width from the size field. Its start address is the base plus a signed 4-bit immediate scaled by the whole vector's footprint in memory. It then walks the elements in ascending order, emitting a write request for each element whose governing predicate bit is set.

Each element in turn advances the address by two bytes, whether or not a write is issued. Only the low halfword of each element container reaches memory.

When the base register field selects the stack pointer:

- The accesses are marked as not tag-checked.
- If any element is active, the stack pointer must be 16-byte aligned. Otherwise the instruction ends with an alignment fault and no writes.

Reserved or non-matching encodings end with an undefined flag and no writes.

Top module: `hstore_seq`

## Requirements
- R1: The instruction is accepted only when bits 31:25 = 1110010, bits 24:23 = 01, bit 20 = 0, bits 15:13 = 111 and the size field bits 22:21 is not 00. Any other word, including size 00, makes `undef_o` pulse for one cycle, in the cycle after the start. No write is issued and `done_o` stays low.
- R2: The first element address is base + sext(bits 19:16) × (VL / esize) × 2, modulo 2^64. Here esize = 8 << size (16, 32 or 64). This address does not depend on the predicate.
- R3: There are VL / esize elements. They are processed in ascending order, and element e has address start + 2·e.
- R4: The write data of element e is vector bits [e·esize+15 : e·esize].
- R5: Element e is active when predicate bit e·(esize/8) is 1. Only active elements produce a write request.
- R6: A request with `wr_valid_o` high and `wr_ready_i` low stays valid, with unchanged address and data, in the next cycle.
- R7: `done_o` pulses for exactly one cycle after the last element has been processed, also when no element is active. At most one of `done_o`, `undef_o` and `align_fault_o` is high in any cycle.
- R8: Base field bits 9:5 equal to 31 selects `sp_i` as the base. Any other value selects `xbase_i`.
- R9: From the cycle after an accepted start, `tag_chk_o` is 1 for a general-register base and 0 for a stack-pointer base.
- R10: With a stack-pointer base, at least one active element and `sp_i[3:0]` not zero, `align_fault_o` pulses for one cycle after the start. No write is issued and `done_o` stays low. With no active element the check is skipped.
- R11: A start strobe is ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new instruction (sampled when idle) |
| insn_i | input | 32 | Instruction word |
| zvec_i | input | VL | Source vector register value |
| pred_i | input | VL/8 | Governing predicate value |
| xbase_i | input | 64 | General-register base value |
| sp_i | input | 64 | Stack pointer value |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts the write request |
| wr_addr_o | output | 64 | Byte address of the write |
| wr_data_o | output | 16 | Halfword written |
| tag_chk_o | output | 1 | Accesses are tag-checked |
| done_o | output | 1 | Instruction completed normally |
| undef_o | output | 1 | Encoding was undefined |
| align_fault_o | output | 1 | Stack pointer misaligned |

## Verification
The bench covers each element size with sparse predicates. A design that read the predicate at bit e instead of the lowest bit of each element's byte group would write the wrong lanes. A design that stopped advancing the address on inactive lanes would shift every later address.

Negative and extreme immediates check that the scaling uses the full vector footprint and wraps past 2^64. A misaligned stack pointer is tried with no active element, where the check must be skipped, and with active elements, where a missing check would leak writes. Stalled handshakes and a start strobe injected mid-instruction expose requests that change under backpressure and sequencers that restart.

// File: rtl/hstore_pkg.sv
package hstore_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_FIN   = 3'd2,
        ST_UNDEF = 3'd3,
        ST_FAULT = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic       legal;
        logic [1:0] sz;
        logic [3:0] imm;
        logic       use_sp;
    } dec_t;

    localparam logic [6:0] OPC_HI   = 7'b1110010;
    localparam logic [1:0] MSZ_HALF = 2'b01;
    localparam logic [2:0] OPC_MID  = 3'b111;
    localparam logic [4:0] SP_INDEX = 5'd31;

endpackage

// File: rtl/hstore_decode.sv
module hstore_decode
    import hstore_pkg::*;
(
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);
    logic pattern_ok;

    always_comb begin
        pattern_ok = (insn_i[31:25] == OPC_HI) &&
                     (insn_i[24:23] == MSZ_HALF) &&
                     (insn_i[20] == 1'b0) &&
                     (insn_i[15:13] == OPC_MID);
        dec_o.sz     = insn_i[22:21];
        dec_o.imm    = insn_i[19:16];
        dec_o.use_sp = (insn_i[9:5] == SP_INDEX);
        dec_o.legal  = pattern_ok && (insn_i[22:21] != 2'b00);
    end
endmodule

// File: rtl/hstore_addr_calc.sv
module hstore_addr_calc #(
    parameter int VL = 256
) (
    input  logic [1:0]      sz_i,
    input  logic [3:0]      imm_i,
    input  logic            use_sp_i,
    input  logic [63:0]     xbase_i,
    input  logic [63:0]     sp_i,
    input  logic [VL/8-1:0] pred_i,
    output logic [63:0]     start_addr_o,
    output logic [$clog2(VL/16)-1:0] last_idx_o,
    output logic            any_active_o,
    output logic            misaligned_o
);
    localparam int PW   = VL / 8;
    localparam int NMAX = VL / 16;
    localparam int IW   = $clog2(NMAX);
    localparam logic [63:0] FOOT_H = 64'(VL / 4);

    logic [63:0] base;
    logic [63:0] step;
    logic [63:0] imm_x;
    logic [PW-1:0] lane_mask;

    always_comb begin
        base  = use_sp_i ? sp_i : xbase_i;
        step  = FOOT_H >> sz_i;
        imm_x = {{60{imm_i[3]}}, imm_i};
        start_addr_o = base + imm_x * step;
        misaligned_o = (sp_i[3:0] != 4'd0);
        case (sz_i)
            2'd2:    last_idx_o = IW'(NMAX / 2 - 1);
            2'd3:    last_idx_o = IW'(NMAX / 4 - 1);
            default: last_idx_o = IW'(NMAX - 1);
        endcase
        for (int i = 0; i < PW; i++) begin
            case (sz_i)
                2'd2:    lane_mask[i] = (i % 4) == 0;
                2'd3:    lane_mask[i] = (i % 8) == 0;
                default: lane_mask[i] = (i % 2) == 0;
            endcase
        end
        any_active_o = |(pred_i & lane_mask);
    end
endmodule

// File: rtl/hstore_lane_sel.sv
module hstore_lane_sel #(
    parameter int VL = 256
) (
    input  logic [VL-1:0]   zvec_i,
    input  logic [VL/8-1:0] pred_i,
    input  logic [1:0]      sz_i,
    input  logic [$clog2(VL/16)-1:0] idx_i,
    output logic [15:0]     data_o,
    output logic            active_o
);
    localparam int PW = VL / 8;

    int unsigned bit_pos;
    int unsigned pbit_pos;
    logic [VL-1:0] vshift;
    logic [PW-1:0] pshift;

    always_comb begin
        bit_pos  = 32'(idx_i) << (32'(sz_i) + 32'd3);
        pbit_pos = 32'(idx_i) << sz_i;
        vshift   = zvec_i >> bit_pos;
        pshift   = pred_i >> pbit_pos;
        data_o   = vshift[15:0];
        active_o = pshift[0];
    end
endmodule

// File: rtl/hstore_seq.sv
module hstore_seq
    import hstore_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [31:0]     insn_i,
    input  logic [VL-1:0]   zvec_i,
    input  logic [VL/8-1:0] pred_i,
    input  logic [63:0]     xbase_i,
    input  logic [63:0]     sp_i,
    output logic            wr_valid_o,
    input  logic            wr_ready_i,
    output logic [63:0]     wr_addr_o,
    output logic [15:0]     wr_data_o,
    output logic            tag_chk_o,
    output logic            done_o,
    output logic            undef_o,
    output logic            align_fault_o
);
    localparam int PW   = VL / 8;
    localparam int NMAX = VL / 16;
    localparam int IW   = $clog2(NMAX);

    typedef struct packed {
        seq_state_e     st;
        logic [1:0]     sz;
        logic           tag;
        logic [IW-1:0]  idx;
        logic [IW-1:0]  last;
        logic [63:0]    addr;
        logic [VL-1:0]  zv;
        logic [PW-1:0]  pr;
    } regs_t;

    regs_t q, d;
    dec_t  dec;

    logic [63:0]   start_addr;
    logic [IW-1:0] last_idx;
    logic          any_active;
    logic          misaligned;
    logic [15:0]   lane_data;
    logic          lane_act;

    logic unused_fields;
    assign unused_fields = ^{insn_i[12:10], insn_i[4:0]};

    hstore_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    hstore_addr_calc #(.VL(VL)) u_addr (
        .sz_i         (dec.sz),
        .imm_i        (dec.imm),
        .use_sp_i     (dec.use_sp),
        .xbase_i      (xbase_i),
        .sp_i         (sp_i),
        .pred_i       (pred_i),
        .start_addr_o (start_addr),
        .last_idx_o   (last_idx),
        .any_active_o (any_active),
        .misaligned_o (misaligned)
    );

    hstore_lane_sel #(.VL(VL)) u_lane (
        .zvec_i   (q.zv),
        .pred_i   (q.pr),
        .sz_i     (q.sz),
        .idx_i    (q.idx),
        .data_o   (lane_data),
        .active_o (lane_act)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (!dec.legal) begin
                        d.st = ST_UNDEF;
                    end else begin
                        d.sz   = dec.sz;
                        d.tag  = !dec.use_sp;
                        d.idx  = '0;
                        d.last = last_idx;
                        d.addr = start_addr;
                        d.zv   = zvec_i;
                        d.pr   = pred_i;
                        if (dec.use_sp && any_active && misaligned) begin
                            d.st = ST_FAULT;
                        end else begin
                            d.st = ST_RUN;
                        end
                    end
                end
            end
            ST_RUN: begin
                if (!lane_act || wr_ready_i) begin
                    if (q.idx == q.last) begin
                        d.st = ST_FIN;
                    end else begin
                        d.idx  = q.idx + 1'b1;
                        d.addr = q.addr + 64'd2;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        wr_valid_o    = (q.st == ST_RUN) && lane_act;
        wr_addr_o     = q.addr;
        wr_data_o     = lane_data;
        tag_chk_o     = q.tag;
        done_o        = (q.st == ST_FIN);
        undef_o       = (q.st == ST_UNDEF);
        align_fault_o = (q.st == ST_FAULT);
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, undef_o, align_fault_o}));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_RUN) && (!lane_act || wr_ready_i) && (q.idx != q.last))
        |=> (q.addr == $past(q.addr) + 64'd2));

    // R10
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault_o |-> ($past(sp_i[3:0]) != 4'd0));

    // R1
    undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |=> !wr_valid_o);

endmodule

// File: tb/hstore_seq_tb_top.sv
module hstore_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VL = 256;
    localparam int PW = VL / 8;

    typedef struct packed {
        logic [1:0]  sz;
        logic [3:0]  imm;
        logic [4:0]  rn;
        logic [31:0] pr;
        logic [63:0] xb;
        logic [63:0] sp;
        logic        stall;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t TBL [NVEC] = '{
        '{2'd1, 4'd0,  5'd3,  32'hFFFF_FFFF, 64'h1000, 64'h0, 1'b0},
        '{2'd1, 4'hF,  5'd5,  32'h0000_1111, 64'h2000, 64'h0, 1'b1},
        '{2'd2, 4'd7,  5'd0,  32'h0F0F_F0F1, 64'h4000_0000, 64'h0, 1'b1},
        '{2'd3, 4'h8,  5'd31, 32'h0101_0101, 64'h0, 64'h8000, 1'b0},
        '{2'd2, 4'd0,  5'd31, 32'h0000_0011, 64'h0, 64'h8008, 1'b0},
        '{2'd2, 4'd3,  5'd31, 32'h0000_0000, 64'h0, 64'h8003, 1'b0},
        '{2'd1, 4'd2,  5'd7,  32'h4000_0001, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 1'b1}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic start_i = 0;
    logic [31:0] insn_i = '0;
    logic [VL-1:0] zvec_i;
    logic [PW-1:0] pred_i = '0;
    logic [63:0] xbase_i = '0;
    logic [63:0] sp_i = '0;
    logic wr_ready_i = 0;
    logic wr_valid_o, tag_chk_o, done_o, undef_o, align_fault_o;
    logic [63:0] wr_addr_o;
    logic [15:0] wr_data_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hstore_seq #(.VL(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .zvec_i(zvec_i), .pred_i(pred_i), .xbase_i(xbase_i), .sp_i(sp_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .tag_chk_o(tag_chk_o),
        .done_o(done_o), .undef_o(undef_o), .align_fault_o(align_fault_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired R7 act=%0d exp=%0d", cycles, 100000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(input logic [1:0] sz, input logic [3:0] imm,
                                            input logic [4:0] rn);
        return {7'b1110010, 2'b01, sz, 1'b0, imm, 3'b111, 3'd2, rn, 5'd9};
    endfunction

    // Expected behaviour derived from the requirements, then driven and compared.
    task automatic run_case(input logic [31:0] ins, input logic [31:0] pr,
                            input logic [63:0] xb, input logic [63:0] spv,
                            input bit stall, input bit poke);
        logic legal;
        int sz, n, esize, expn, got, kind, outk, cyc;
        logic signed [3:0] i4;
        longint im;
        logic [63:0] base, st, pa;
        logic [15:0] pd;
        logic [63:0] ea [16];
        logic [15:0] ed [16];
        bit any, use_sp, prev_stall, fin;
        legal = (ins[31:25] == 7'b1110010) && (ins[24:23] == 2'b01) && !ins[20] &&
                (ins[15:13] == 3'b111) && (ins[22:21] != 2'b00);
        sz = int'(ins[22:21]);
        esize = 8 << sz;
        n = VL / esize;
        i4 = ins[19:16];
        im = longint'(i4);
        use_sp = (ins[9:5] == 5'd31);
        base = use_sp ? spv : xb;
        st = base + 64'(im * longint'(n) * 2);
        expn = 0;
        any = 0;
        for (int e = 0; e < n; e++) begin
            if (pr[e << sz]) begin
                any = 1;
                ea[expn] = st + 64'(2 * e);
                ed[expn] = zvec_i[e*esize +: 16];
                expn++;
            end
        end
        if (!legal) kind = 1;
        else if (use_sp && any && spv[3:0] != 4'd0) kind = 2;
        else kind = 0;
        if (kind != 0) expn = 0;

        @(negedge clk);
        insn_i = ins; pred_i = pr; xbase_i = xb; sp_i = spv; start_i = 1; wr_ready_i = 0;
        @(negedge clk);
        start_i = 0;
        got = 0; outk = -1; cyc = 0; fin = 0; prev_stall = 0; pa = '0; pd = '0;
        while (!fin && cyc < 400) begin
            wr_ready_i = !stall || (cyc % 3 == 2);
            if (poke && cyc == 1) begin start_i = 1; insn_i = 32'h0; end
            if (poke && cyc == 2) start_i = 0;
            #1;
            if (prev_stall)
                chk(wr_valid_o && wr_addr_o == pa && wr_data_o == {48'h0, pd} [15:0],
                    "R6", "held request", wr_addr_o, pa);
            if (done_o) begin outk = 0; fin = 1; end
            if (undef_o) begin outk = 1; fin = 1; end
            if (align_fault_o) begin outk = 2; fin = 1; end
            if (wr_valid_o) begin
                chk(tag_chk_o == !use_sp, "R9", "tag flag", 64'(tag_chk_o), 64'(!use_sp));
                if (wr_ready_i) begin
                    if (got < expn) begin
                        chk(wr_addr_o == ea[got], "R2 R3 R8", "write address", wr_addr_o, ea[got]);
                        chk(wr_data_o == ed[got], "R4", "write data", 64'(wr_data_o), 64'(ed[got]));
                    end
                    got++;
                    prev_stall = 0;
                end else begin
                    prev_stall = 1; pa = wr_addr_o; pd = wr_data_o;
                end
            end else begin
                prev_stall = 0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 0;
        wr_ready_i = 0;
        chk(outk == kind, kind == 1 ? "R1" : (kind == 2 ? "R10" : "R7 R11"),
            "outcome kind", 64'(outk), 64'(kind));
        chk(got == expn, "R5", "write count", 64'(got), 64'(expn));
        #1;
        chk(!done_o && !undef_o && !align_fault_o, "R7", "single pulse",
            64'({done_o, undef_o, align_fault_o}), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < VL / 8; i++) zvec_i[i*8 +: 8] = 8'(i * 37 + 5);
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(!wr_valid_o && !done_o && !undef_o && !align_fault_o && !tag_chk_o,
            "R7", "reset idle", 64'({wr_valid_o, done_o, undef_o, align_fault_o, tag_chk_o}), 64'd0);

        for (int v = 0; v < NVEC; v++) begin
            run_case(mk_insn(TBL[v].sz, TBL[v].imm, TBL[v].rn), TBL[v].pr,
                     TBL[v].xb, TBL[v].sp, TBL[v].stall, 1'b0);
        end

        // R1: reserved size field
        run_case(mk_insn(2'b00, 4'd1, 5'd2), 32'hFFFF_FFFF, 64'h100, 64'h0, 1'b0, 1'b0);
        // R1: wrong fixed bit 20
        run_case(mk_insn(2'b01, 4'd1, 5'd2) | 32'h0010_0000, 32'hFFFF_FFFF, 64'h100, 64'h0, 1'b0, 1'b0);
        // R11: start strobe during a run must be ignored
        run_case(mk_insn(2'b10, 4'd1, 5'd4), 32'h1111_1111, 64'h3000, 64'h0, 1'b1, 1'b1);
        // R10: misaligned SP with 64-bit elements, one active lane at the top
        run_case(mk_insn(2'b11, 4'd0, 5'd31), 32'h0100_0000, 64'h0, 64'h8004, 1'b0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule